// File: doc/BRIEF.md
# Product-Term Macrocell with Foldback Expander

This block is one logic cell of a sum-of-products programmable array. A shared term-input vector is formed from the external input bus, the cell's own stored flip-flop bit, the cell's own expander output and expander outputs arriving from neighbouring cells. Seven programmable AND terms are evaluated over that vector. Three of them are ORed into a sum, and a polarity bit inverts the sum through an XOR. The other four terms drive the flip-flop's clear, its preset, an alternative clock source, and a NAND expander whose output widens the logic of this cell and of its neighbours.

The single flip-flop can be bypassed, so the pin path carries either the combinational XOR result or the stored bit. When the product-term clock is chosen, the term is sampled on the global clock and a rising edge of it enables one load. Clear and preset override the flip-flop output in the same cycle and are also stored at the next edge. All configuration is loaded serially through a shift chain while the configuration-mode input is high. During that time every output is held low.

Top module: `pterm_macrocell`

## Requirements
- R1: A product term is the AND of its enabled literals. For term-input index i, configuration bit 2i enables the true literal and bit 2i+1 enables the complemented literal. A term with no literal enabled evaluates to 1. A term that enables both literals of one input evaluates to 0.
- R2: When the register-select mode bit is 0, pin_out equals (sum term 0 OR sum term 1 OR sum term 2) XOR the polarity mode bit, with no clock delay.
- R3: When the register-select bit is 1, pin_out equals fb_out. With internal clocking off, the flip-flop loads the XOR result at every rising edge of clk.
- R4: While the clear term is 1, fb_out is 0 in the same cycle whatever the preset term, and the flip-flop stores 0 at the next clk edge.
- R5: While the preset term is 1 and the clear term is 0, fb_out is 1 in the same cycle, and the flip-flop stores 1 at the next clk edge.
- R6: When the internal-clock mode bit is 1, the flip-flop loads the XOR result only at a clk edge where the clock term is 1 and was 0 at the previous clk edge. At any other edge it holds its value, unless clear or preset is active.
- R7: exp_out is the NAND of the expander term. The expander term ignores the cell's own expander literal. Term-input index N_IN+1 carries the cell's own expander output to the other terms, and index N_IN+2+j carries exp_in[j].
- R8: Term-input index N_IN carries the stored flip-flop bit (local feedback). Term-input indices 0..N_IN-1 carry din. fb_out carries the flip-flop value after the clear/preset override.
- R9: With cfg_mode and cfg_shift high, each clk edge shifts cfg_din into bit 0 of the configuration word, and the earlier bits move up by one. Bit 0 is polarity, bit 1 is register-select and bit 2 is internal-clock. Term k occupies the 2*W bits starting at 3+k*2*W, where W = N_IN+2+N_XIN. The terms in order are sum 0, sum 1, sum 2, preset, clear, clock and expander.
- R10: While cfg_mode is 1, pin_out, fb_out and exp_out are 0. The flip-flop and the clock-term history are cleared at each clk edge.
- R11: Reset clears the whole configuration word. With an all-zero word outside configuration mode, exp_out is 0, pin_out is 1 and fb_out is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Global clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_mode | input | 1 | High selects configuration mode |
| cfg_shift | input | 1 | Shift enable for the configuration chain |
| cfg_din | input | 1 | Serial configuration data |
| din | input | N_IN | Input bus from the interconnect |
| exp_in | input | N_XIN | Expander outputs of neighbouring cells |
| pin_out | output | 1 | Output toward the pin path |
| fb_out | output | 1 | Global feedback of the flip-flop value |
| exp_out | output | 1 | This cell's expander output |

## Verification
Clear and preset are both driven by product terms, so they can be true in the same cycle. The product-term clock can also rise while either of them is active. A configuration is loaded whose preset and clear terms share one input, and the input bus is then swept through every value in the registered mode, which reaches all four combinations of the two override terms. A separate sequence varies the clock-term input against the data input. The bench checks each cycle against a model built from the requirements. The model applies clear ahead of preset, then preset ahead of any clocked load, both for the value visible in that cycle and for the value stored at the next edge.

// File: rtl/mc_pkg.sv
package mc_pkg;

  localparam int NUM_TERMS = 7;
  localparam int MODE_BITS = 3;

  localparam int TERM_SUM0    = 0;
  localparam int TERM_SUM1    = 1;
  localparam int TERM_SUM2    = 2;
  localparam int TERM_PRESET  = 3;
  localparam int TERM_CLEAR   = 4;
  localparam int TERM_CLOCK   = 5;
  localparam int TERM_EXPAND  = 6;
  localparam int NUM_MAIN     = 6;

  typedef struct packed {
    logic clk_int;
    logic reg_sel;
    logic pol_inv;
  } mc_mode_t;

endpackage

// File: rtl/mc_rst_sync.sv
module mc_rst_sync (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);

  logic stage_q;

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) begin
      stage_q    <= 1'b0;
      rst_n_sync <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_n_sync <= stage_q;
    end
  end

endmodule

// File: rtl/mc_cfg_chain.sv
module mc_cfg_chain #(
  parameter int LEN = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           shift_en,
  input  logic           ser_in,
  output logic [LEN-1:0] bits
);

  logic [LEN-1:0] bits_d;

  always_comb begin
    bits_d = bits;
    if (shift_en) begin
      bits_d = {bits[LEN-2:0], ser_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits <= '0;
    end else begin
      bits <= bits_d;
    end
  end

endmodule

// File: rtl/mc_pterm.sv
module mc_pterm #(
  parameter int W = 8
) (
  input  logic [2*W-1:0] lits,
  input  logic [W-1:0]   x,
  output logic           hit
);

  logic [W-1:0] kill;

  for (genvar i = 0; i < W; i++) begin : g_lit
    assign kill[i] = (lits[2*i] & ~x[i]) | (lits[2*i+1] & x[i]);
  end

  assign hit = ~|kill;

endmodule

// File: rtl/mc_cell_reg.sv
module mc_cell_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_mode,
  input  logic clk_int,
  input  logic d,
  input  logic pre,
  input  logic clr,
  input  logic clk_term,
  output logic ct_q,
  output logic q_raw,
  output logic q_eff
);

  logic ct_edge;
  logic ld_en;
  logic q_d;
  logic ct_d;

  always_comb begin
    ct_edge = clk_term & ~ct_q;
    ld_en   = clk_int ? ct_edge : 1'b1;
    ct_d    = cfg_mode ? 1'b0 : clk_term;
    q_d     = q_raw;
    if (cfg_mode) begin
      q_d = 1'b0;
    end else if (clr) begin
      q_d = 1'b0;
    end else if (pre) begin
      q_d = 1'b1;
    end else if (ld_en) begin
      q_d = d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_raw <= 1'b0;
      ct_q  <= 1'b0;
    end else begin
      q_raw <= q_d;
      ct_q  <= ct_d;
    end
  end

  always_comb begin
    if (cfg_mode || clr) begin
      q_eff = 1'b0;
    end else if (pre) begin
      q_eff = 1'b1;
    end else begin
      q_eff = q_raw;
    end
  end

endmodule

// File: rtl/pterm_macrocell.sv
module pterm_macrocell
  import mc_pkg::*;
#(
  parameter int N_IN  = 4,
  parameter int N_XIN = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_mode,
  input  logic             cfg_shift,
  input  logic             cfg_din,
  input  logic [N_IN-1:0]  din,
  input  logic [N_XIN-1:0] exp_in,
  output logic             pin_out,
  output logic             fb_out,
  output logic             exp_out
);

  localparam int W       = N_IN + 2 + N_XIN;
  localparam int LIT_W   = 2 * W;
  localparam int OWN_IDX = N_IN + 1;
  localparam int CFG_LEN = MODE_BITS + NUM_TERMS * LIT_W;
  localparam logic [LIT_W-1:0] OWN_LIT_MASK = LIT_W'(2'b11) << (2 * OWN_IDX);

  logic               rst_n_sync;
  logic [CFG_LEN-1:0] cfg_bits;
  mc_mode_t           mode;
  logic               q_raw;
  logic               q_eff;
  logic               ct_q;
  logic               exp_hit;
  logic               exp_term;
  logic [W-1:0]       x_full;
  logic [W-1:0]       x_exp;
  logic [NUM_MAIN-1:0] pt;
  logic               sum_or;
  logic               xr;

  mc_rst_sync u_rst (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_n_sync)
  );

  mc_cfg_chain #(.LEN(CFG_LEN)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .shift_en (cfg_mode & cfg_shift),
    .ser_in   (cfg_din),
    .bits     (cfg_bits)
  );

  assign mode = mc_mode_t'(cfg_bits[MODE_BITS-1:0]);

  assign x_exp  = {exp_in, 1'b0, q_raw, din};
  assign x_full = {exp_in, exp_term, q_raw, din};

  for (genvar k = 0; k < NUM_MAIN; k++) begin : g_term
    mc_pterm #(.W(W)) u_pt (
      .lits (cfg_bits[MODE_BITS + k*LIT_W +: LIT_W]),
      .x    (x_full),
      .hit  (pt[k])
    );
  end

  mc_pterm #(.W(W)) u_exp (
    .lits (cfg_bits[MODE_BITS + TERM_EXPAND*LIT_W +: LIT_W] & ~OWN_LIT_MASK),
    .x    (x_exp),
    .hit  (exp_hit)
  );

  assign exp_term = ~exp_hit;
  assign sum_or   = pt[TERM_SUM0] | pt[TERM_SUM1] | pt[TERM_SUM2];
  assign xr       = sum_or ^ mode.pol_inv;

  mc_cell_reg u_reg (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .cfg_mode (cfg_mode),
    .clk_int  (mode.clk_int),
    .d        (xr),
    .pre      (pt[TERM_PRESET]),
    .clr      (pt[TERM_CLEAR]),
    .clk_term (pt[TERM_CLOCK]),
    .ct_q     (ct_q),
    .q_raw    (q_raw),
    .q_eff    (q_eff)
  );

  always_comb begin
    if (cfg_mode) begin
      pin_out = 1'b0;
      exp_out = 1'b0;
    end else begin
      pin_out = mode.reg_sel ? q_eff : xr;
      exp_out = exp_term;
    end
  end

  assign fb_out = q_eff;

endmodule

// File: rtl/mc_checker.sv
module mc_checker (
  input logic clk,
  input logic rst_n,
  input logic cfg_mode,
  input logic reg_sel,
  input logic clk_int,
  input logic pol_inv,
  input logic sum_or,
  input logic pre,
  input logic clr,
  input logic clk_term,
  input logic ct_q,
  input logic q_raw,
  input logic pin_out,
  input logic fb_out,
  input logic exp_out
);

  AST_CFG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_mode |-> (!pin_out && !fb_out && !exp_out)); // R10

  AST_COMB_PATH: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_mode && !reg_sel) |-> (pin_out == (sum_or ^ pol_inv))); // R2

  AST_REG_PATH: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_mode && reg_sel) |-> (pin_out == fb_out)); // R3

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_mode && clr) |-> !fb_out); // R4

  AST_CLEAR_STORES: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_mode && clr) |=> !q_raw); // R4

  AST_PRESET_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_mode && pre && !clr) |-> fb_out); // R5

  AST_NO_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_mode && clk_int && !clr && !pre && !(clk_term && !ct_q)) |=> $stable(q_raw)); // R6

endmodule

bind pterm_macrocell mc_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n_sync),
  .cfg_mode (cfg_mode),
  .reg_sel  (mode.reg_sel),
  .clk_int  (mode.clk_int),
  .pol_inv  (mode.pol_inv),
  .sum_or   (sum_or),
  .pre      (pt[3]),
  .clr      (pt[4]),
  .clk_term (pt[5]),
  .ct_q     (ct_q),
  .q_raw    (q_raw),
  .pin_out  (pin_out),
  .fb_out   (fb_out),
  .exp_out  (exp_out)
);

// File: tb/pterm_macrocell_test.sv
module pterm_macrocell_test;

  localparam int N_IN  = 4;
  localparam int N_XIN = 2;
  localparam int W     = N_IN + 2 + N_XIN;
  localparam int LW    = 2 * W;
  localparam int NT    = 7;
  localparam int LEN   = 3 + NT * LW;

  logic             clk;
  logic             rst_n;
  logic             cfg_mode;
  logic             cfg_shift;
  logic             cfg_din;
  logic [N_IN-1:0]  din;
  logic [N_XIN-1:0] exp_in;
  logic             pin_out;
  logic             fb_out;
  logic             exp_out;

  logic [LW-1:0] tm [NT];
  logic m_pol, m_rsel, m_cint;
  logic q_m, ctq_m;
  int   checks;
  int   errors;

  pterm_macrocell #(.N_IN(N_IN), .N_XIN(N_XIN)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_shift(cfg_shift),
    .cfg_din(cfg_din), .din(din), .exp_in(exp_in),
    .pin_out(pin_out), .fb_out(fb_out), .exp_out(exp_out)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [LW-1:0] lt(int i);
    return LW'(1) << (2 * i);
  endfunction

  function automatic logic [LW-1:0] lc(int i);
    return LW'(1) << (2 * i + 1);
  endfunction

  // R1: a term is 1 unless an enabled literal is false
  function automatic logic eval_t(logic [LW-1:0] t, logic [W-1:0] x);
    logic r;
    r = 1'b1;
    for (int i = 0; i < W; i++) begin
      if (t[2*i] && !x[i]) r = 1'b0;
      if (t[2*i+1] && x[i]) r = 1'b0;
    end
    return r;
  endfunction

  task automatic model(output logic xr, output logic pr, output logic cl,
                       output logic ct, output logic ev);
    logic [W-1:0]  x;
    logic [LW-1:0] te;
    te = tm[6] & ~(lt(N_IN + 1) | lc(N_IN + 1));
    x  = {exp_in, 1'b0, q_m, din};
    ev = ~eval_t(te, x);
    x[N_IN + 1] = ev;
    xr = (eval_t(tm[0], x) | eval_t(tm[1], x) | eval_t(tm[2], x)) ^ m_pol;
    pr = eval_t(tm[3], x);
    cl = eval_t(tm[4], x);
    ct = eval_t(tm[5], x);
  endtask

  always @(posedge clk) begin
    logic xr, pr, cl, ct, ev;
    if (cfg_mode) begin
      q_m   = 1'b0;
      ctq_m = 1'b0;
    end else begin
      model(xr, pr, cl, ct, ev);
      if (cl) q_m = 1'b0;
      else if (pr) q_m = 1'b1;
      else if (!m_cint || (ct && !ctq_m)) q_m = xr;
      ctq_m = ct;
    end
  end

  task automatic chk(string tag);
    logic xr, pr, cl, ct, ev, qe;
    logic [2:0] expv, act;
    if (cfg_mode) begin
      expv = 3'b000;
    end else begin
      model(xr, pr, cl, ct, ev);
      qe   = cl ? 1'b0 : (pr ? 1'b1 : q_m);
      expv = {m_rsel ? qe : xr, qe, ev};
    end
    act = {pin_out, fb_out, exp_out};
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: {pin,fb,exp} actual %b expected %b (din=%h exp_in=%h)",
               tag, act, expv, din, exp_in);
    end
  endtask

  task automatic step(logic [N_IN-1:0] d, logic [N_XIN-1:0] e, string tag);
    @(negedge clk);
    din    = d;
    exp_in = e;
    #1;
    chk(tag);
  endtask

  task automatic base();
    for (int k = 0; k < NT; k++) tm[k] = lt(0) | lc(0);
    m_pol  = 1'b0;
    m_rsel = 1'b0;
    m_cint = 1'b0;
  endtask

  // R9: serial load, first bit sent ends at the top of the word
  task automatic load();
    logic [LEN-1:0] v;
    v    = '0;
    v[0] = m_pol;
    v[1] = m_rsel;
    v[2] = m_cint;
    for (int k = 0; k < NT; k++) v[3 + k*LW +: LW] = tm[k];
    @(negedge clk);
    cfg_mode = 1'b1;
    for (int i = LEN - 1; i >= 0; i--) begin
      @(negedge clk);
      cfg_shift = 1'b1;
      cfg_din   = v[i];
      if (i % 32 == 0) begin
        #1;
        chk("R10");
      end
    end
    @(negedge clk);
    cfg_shift = 1'b0;
    #1;
    chk("R10");
    @(negedge clk);
    cfg_mode = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    checks = 0; errors = 0;
    rst_n = 1'b0; cfg_mode = 1'b1; cfg_shift = 1'b0; cfg_din = 1'b0;
    din = '0; exp_in = '0; q_m = 1'b0; ctq_m = 1'b0;
    for (int k = 0; k < NT; k++) tm[k] = '0;
    m_pol = 1'b0; m_rsel = 1'b0; m_cint = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk("R10");
    @(negedge clk);
    cfg_mode = 1'b0;
    // R11 with R1: empty terms after reset
    step(4'h0, 2'b00, "R11 R1");
    step(4'h9, 2'b11, "R11 R1");

    // R2: combinational sum of products, both polarities
    base();
    tm[0] = lt(0) | lc(1);
    tm[1] = lt(2) | lt(3);
    load();
    for (int d = 0; d < 16; d++) step(N_IN'(d), 2'b00, "R2 R9 R1");
    m_pol = 1'b1;
    load();
    for (int d = 0; d < 16; d++) step(N_IN'(d), 2'b00, "R2 R9");

    // R3: registered path, both polarities
    m_rsel = 1'b1;
    m_pol  = 1'b0;
    load();
    for (int d = 0; d < 16; d++) step(N_IN'((d * 7) % 16), 2'b00, "R3");
    m_pol = 1'b1;
    load();
    for (int d = 0; d < 16; d++) step(N_IN'((d * 11) % 16), 2'b00, "R3");

    // R4 R5: preset and clear, including both at once
    base();
    m_rsel = 1'b1;
    tm[0] = lt(3);
    tm[3] = lt(0) | lt(1);
    tm[4] = lt(0) | lt(2);
    load();
    for (int r = 0; r < 2; r++)
      for (int d = 0; d < 16; d++) step(N_IN'(d ^ (r * 5)), 2'b00, "R4 R5");

    // R6: product-term clock on din[3], data on din[0]
    base();
    m_rsel = 1'b1;
    m_cint = 1'b1;
    tm[0] = lt(0);
    tm[5] = lt(3);
    load();
    for (int i = 0; i < 64; i++) step(N_IN'((i * 5 + i / 3) % 16), 2'b00, "R6");

    // R7: expander, own literal ignored, neighbour inputs used
    base();
    tm[6] = lt(0) | lt(1) | lt(N_IN + 1);
    tm[0] = lt(N_IN + 1) | lc(2);
    tm[1] = lt(N_IN + 2) | lt(3);
    tm[2] = lc(N_IN + 3) | lt(2);
    load();
    for (int e = 0; e < 4; e++)
      for (int d = 0; d < 16; d++) step(N_IN'(d), N_XIN'(e), "R7");

    // R8: local feedback, q_next = q XNOR din[0]
    base();
    m_rsel = 1'b1;
    tm[0] = lc(N_IN) | lc(0);
    tm[1] = lt(N_IN) | lt(0);
    load();
    for (int i = 0; i < 32; i++) step(N_IN'((i * 3) % 16), 2'b00, "R8");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule